// File: doc/BRIEF.md
# Byte-Loaded Modulo Timer Counter

This block is a free-running 16-bit timer counter. Its wrap point comes from a modulo register that an 8-bit processor loads as two bytes: the high byte first, then the low byte. On a timer tick where the count equals the modulo value, the counter goes back to zero and an overflow flag sets. The flag can raise an interrupt. Software clears the flag with a read-then-write-zero sequence on a control/status byte. A stop bit in that same byte forces the counter to zero and holds it there, so software can park the counter while it loads a new modulo value.

The modulo value is wider than the bus. While only its high byte has been written, the value is incomplete. A write to the high byte therefore arms an inhibit. The inhibit stops the flag from setting and masks the interrupt until the low byte arrives, so a half-loaded value cannot produce a spurious overflow. The counter advances only on cycles where the timer tick enable input is high.

Top module: `mtmr_top`

## Requirements
- R1: After reset the modulo value reads 0xFFFF, the count reads 0x0000, the control/status byte reads 0x20 (stopped, interrupt disabled, flag clear) and `irq` is low.
- R2: While not stopped, the count rises by exactly one on each cycle with `tick_en` high and holds on cycles with `tick_en` low.
- R3: On a tick where the count equals the modulo value, the count becomes 0x0000 and the overflow flag sets, so one period is modulo+1 ticks.
- R4: The modulo high byte is at address 0x54 and the low byte at 0x55. The count high byte is at 0x51 and the count low byte at 0x52. Each read returns the value currently held.
- R5: A write to 0x54 blocks the overflow flag from setting until a write to 0x55. The counter still wraps during that window.
- R6: The flag clears only when the control/status byte is read while the flag is set and the next write to that byte has bit 7 at 0. Writing bit 7 as 1, or writing 0 without that prior read, leaves the flag set.
- R7: With the stop bit (bit 5 of the control/status byte) at 1, the count is forced to 0x0000 and ignores ticks.
- R8: `irq` is high exactly when the flag is set, the interrupt enable (bit 6) is 1 and no high-byte-only write is pending.
- R9: The control/status byte is at 0x50. Bit 7 is the flag, bit 6 the interrupt enable and bit 5 the stop bit. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick enable; the counter advances on cycles where this is high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest situation to reach is a counter wrap that happens while only the high modulo byte has been written. The stimulus writes the high byte and leaves the low byte unwritten. It then ticks the counter through a full period. It confirms that the count returns to zero while the flag stays clear. A second case writes the high byte while the flag is already set and the interrupt is enabled, to show that `irq` is masked until the low byte lands. The flag-clear sequence is also driven in its failing orders: a write with no prior read, and a write of 1 after a read.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int CNT_W_DEF  = 16;
    localparam int BYTE_W_DEF = 8;
    localparam int ADDR_W_DEF = 8;

    localparam int CTRL_ADDR_DEF = 'h50;
    localparam int CNT_ADDR_DEF  = 'h51;
    localparam int MOD_ADDR_DEF  = 'h54;

    typedef struct packed {
        logic ie;
        logic stop;
    } ctrl_t;

    typedef struct packed {
        logic wr;
        logic rd;
    } ctrl_access_t;

    function automatic logic is_high_byte(input int idx);
        return idx != 0;
    endfunction

endpackage

// File: rtl/mtmr_regs.sv
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int CNT_W     = CNT_W_DEF,
    parameter int BYTE_W    = BYTE_W_DEF,
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int CTRL_ADDR = CTRL_ADDR_DEF,
    parameter int CNT_ADDR  = CNT_ADDR_DEF,
    parameter int MOD_ADDR  = MOD_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              flag,
    output logic [CNT_W-1:0]  modv,
    output ctrl_t             ctrl,
    output ctrl_access_t      ctrl_acc,
    output logic              inhibit
);
    localparam int NB = CNT_W / BYTE_W;

    logic [NB-1:0] hi_wr;
    logic [NB-1:0] lo_wr;

    assign ctrl_acc.wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign ctrl_acc.rd = bus_rd && (bus_addr == ADDR_W'(CTRL_ADDR));

    // Modulo bytes: most significant byte at the lowest address
    for (genvar gi = 0; gi < NB; gi++) begin : g_mod
        localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(MOD_ADDR + NB - 1 - gi);
        logic hit;
        assign hit = bus_wr && (bus_addr == BYTE_ADDR);
        if (is_high_byte(gi)) begin : g_hi
            assign hi_wr[gi] = hit;
            assign lo_wr[gi] = 1'b0;
        end else begin : g_lo
            assign hi_wr[gi] = 1'b0;
            assign lo_wr[gi] = hit;
        end
        always_ff @(posedge clk) begin
            if (rst)
                modv[gi*BYTE_W +: BYTE_W] <= '1;
            else if (hit)
                modv[gi*BYTE_W +: BYTE_W] <= bus_wdata;
        end
    end

    // Write-in-progress inhibit: set by an upper byte, released by the low byte
    always_ff @(posedge clk) begin
        if (rst)
            inhibit <= 1'b0;
        else if (|lo_wr)
            inhibit <= 1'b0;
        else if (|hi_wr)
            inhibit <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.ie   <= 1'b0;
            ctrl.stop <= 1'b1;
        end else if (ctrl_acc.wr) begin
            ctrl.ie   <= bus_wdata[BYTE_W-2];
            ctrl.stop <= bus_wdata[BYTE_W-3];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
            bus_rdata[BYTE_W-1] = flag;
            bus_rdata[BYTE_W-2] = ctrl.ie;
            bus_rdata[BYTE_W-3] = ctrl.stop;
        end
        for (int i = 0; i < NB; i++) begin
            if (bus_addr == ADDR_W'(CNT_ADDR + NB - 1 - i))
                bus_rdata = count[i*BYTE_W +: BYTE_W];
            if (bus_addr == ADDR_W'(MOD_ADDR + NB - 1 - i))
                bus_rdata = modv[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter
    import mtmr_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             stop,
    input  logic [CNT_W-1:0] modv,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic at_mod;

    assign at_mod = (count == modv);
    assign wrap   = tick_en && !stop && at_mod;

    always_ff @(posedge clk) begin
        if (rst || stop)
            count <= '0;
        else if (tick_en)
            count <= at_mod ? '0 : count + 1'b1;
    end

endmodule

// File: rtl/mtmr_flag.sv
module mtmr_flag
    import mtmr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap,
    input  logic         inhibit,
    input  ctrl_access_t ctrl_acc,
    input  logic         wr_flag_bit,
    input  logic         ie,
    output logic         flag,
    output logic         irq
);
    logic armed;

    // Clear handshake: a read that sees the flag set arms the next write
    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (ctrl_acc.wr)
            armed <= 1'b0;
        else if (ctrl_acc.rd && flag)
            armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (wrap && !inhibit)
            flag <= 1'b1;
        else if (ctrl_acc.wr && armed && !wr_flag_bit)
            flag <= 1'b0;
    end

    assign irq = flag && ie && !inhibit;

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int CNT_W     = CNT_W_DEF,
    parameter int BYTE_W    = BYTE_W_DEF,
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int CTRL_ADDR = CTRL_ADDR_DEF,
    parameter int CNT_ADDR  = CNT_ADDR_DEF,
    parameter int MOD_ADDR  = MOD_ADDR_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] modv_w;
    logic             wrap_w;
    logic             flag_w;
    logic             inhibit_w;
    ctrl_t            ctrl_w;
    ctrl_access_t     acc_w;

    mtmr_regs #(
        .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
        .CTRL_ADDR(CTRL_ADDR), .CNT_ADDR(CNT_ADDR), .MOD_ADDR(MOD_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count_w), .flag(flag_w),
        .modv(modv_w), .ctrl(ctrl_w), .ctrl_acc(acc_w), .inhibit(inhibit_w)
    );

    mtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en), .stop(ctrl_w.stop),
        .modv(modv_w), .count(count_w), .wrap(wrap_w)
    );

    mtmr_flag u_flag (
        .clk(clk), .rst(rst), .wrap(wrap_w), .inhibit(inhibit_w),
        .ctrl_acc(acc_w), .wr_flag_bit(bus_wdata[BYTE_W-1]), .ie(ctrl_w.ie),
        .flag(flag_w), .irq(irq)
    );

endmodule

module mtmr_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    parameter int CTRL_ADDR = 'h50
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  modv,
    input logic              stop,
    input logic              inhibit,
    input logic              flag,
    input logic              irq
);
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !stop && count != modv) |=> count == $past(count) + 1'b1);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !stop) |=> $stable(count));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !stop && count == modv) |=> count == '0);

    assert_no_flag_inhibit_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> !$past(inhibit));

    assert_clear_by_write_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)));

    assert_stop_R7: assert property (@(posedge clk) disable iff (rst)
        stop |=> count == '0);

    assert_irq_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

endmodule

bind mtmr_top mtmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .count(count_w), .modv(modv_w), .stop(ctrl_w.stop), .inhibit(inhibit_w),
    .flag(flag_w), .irq(irq)
);

// File: tb/mtmr_top_tb.sv
module mtmr_top_tb;
    localparam logic [7:0] A_CTRL = 8'h50;
    localparam logic [7:0] A_CNTH = 8'h51;
    localparam logic [7:0] A_CNTL = 8'h52;
    localparam logic [7:0] A_MODH = 8'h54;
    localparam logic [7:0] A_MODL = 8'h55;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t exp_q[$];

    // Reference model state
    logic [15:0] m_cnt = 16'h0000;
    logic [15:0] m_mod = 16'hFFFF;
    bit m_flag = 0, m_ie = 0, m_stop = 1, m_inh = 0, m_arm = 0;

    always #2.5 clk = ~clk;

    mtmr_top u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Monitor: pop expected read data and compare in mid-cycle
    always @(negedge clk) begin
        if (bus_rd && !rst) begin
            item_t it;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expectation, actual %02h expected none", bus_rdata);
            end else begin
                it = exp_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    function automatic logic [7:0] ctrl_byte();
        return {m_flag, m_ie, m_stop, 5'b0};
    endfunction

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        exp_q.push_back(it);
        bus_rd = 1'b1;
        bus_addr = a;
        if (a == A_CTRL && m_flag) m_arm = 1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if (a == A_MODH) begin m_mod[15:8] = d; m_inh = 1; end
        if (a == A_MODL) begin m_mod[7:0] = d; m_inh = 0; end
        if (a == A_CTRL) begin
            if (m_arm && !d[7]) m_flag = 0;
            m_arm = 0;
            m_ie = d[6];
            m_stop = d[5];
            @(posedge clk); #1;
            if (m_stop) m_cnt = 16'h0000;
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(posedge clk);
            if (!m_stop) begin
                if (m_cnt == m_mod) begin
                    m_cnt = 16'h0000;
                    if (!m_inh) m_flag = 1;
                end else begin
                    m_cnt = m_cnt + 16'h1;
                end
            end
            #1;
            tick_en = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic chk_cnt(input string tag);
        rd(A_CNTH, m_cnt[15:8], tag);
        rd(A_CNTL, m_cnt[7:0], tag);
    endtask

    task automatic chk_irq(input string tag);
        logic e;
        e = m_flag && m_ie && !m_inh;
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values, R9 layout
        rd(A_MODH, 8'hFF, "R1 modh reset");
        rd(A_MODL, 8'hFF, "R1 modl reset");
        chk_cnt("R1 count reset");
        rd(A_CTRL, 8'h20, "R1 R9 ctrl reset");
        chk_irq("R1 irq reset");

        // R7 stopped counter ignores ticks
        tick(3);
        chk_cnt("R7 stopped count");

        // R4 load modulo 0x0004, read back
        wr(A_MODH, 8'h00);
        wr(A_MODL, 8'h04);
        rd(A_MODH, 8'h00, "R4 modh readback");
        rd(A_MODL, 8'h04, "R4 modl readback");

        // R2 counting, R3 wrap and flag, R8 irq
        wr(A_CTRL, 8'h40);
        tick(3);
        chk_cnt("R2 count after 3 ticks");
        idle(4);
        chk_cnt("R2 count holds without ticks");
        tick(1);
        rd(A_CTRL, ctrl_byte(), "R3 flag clear before wrap");
        tick(1);
        chk_cnt("R3 count wrapped to zero");
        rd(A_CTRL, ctrl_byte(), "R3 R9 flag set after wrap");
        chk_irq("R8 irq with flag and enable");

        // R6 clear sequences
        m_arm = 0;
        wr(A_CTRL, 8'hC0);
        rd(A_CTRL, ctrl_byte(), "R6 write 1 keeps flag");
        wr(A_CTRL, 8'hC0);
        rd(A_CTRL, 8'hC0, "R6 write 1 after read keeps flag");
        wr(A_CTRL, 8'h40);
        rd(A_CTRL, 8'h40, "R6 read then write 0 clears");
        chk_irq("R6 irq low after clear");
        tick(5);
        wr(A_CTRL, 8'h40);
        rd(A_CTRL, 8'hC0, "R6 write 0 without read keeps flag");

        // R8 inhibit masks irq while flag set
        chk_irq("R8 irq before high write");
        wr(A_MODH, 8'h00);
        chk_irq("R8 irq masked by pending high byte");
        wr(A_MODL, 8'h04);
        chk_irq("R8 irq back after low byte");

        // clear flag
        rd(A_CTRL, ctrl_byte(), "R6 read before clear");
        wr(A_CTRL, 8'h40);

        // R5 wrap while only high byte written
        wr(A_MODH, 8'h00);
        tick(5);
        chk_cnt("R5 counter wraps while inhibited");
        rd(A_CTRL, 8'h40, "R5 flag blocked while inhibited");
        wr(A_MODL, 8'h04);
        tick(5);
        rd(A_CTRL, 8'hC0, "R5 flag sets after low byte");
        chk_irq("R8 irq after inhibit release");

        // R7 stop forces zero
        tick(2);
        wr(A_CTRL, 8'h60);
        chk_cnt("R7 stop zeroes count");
        tick(4);
        chk_cnt("R7 stop holds zero");
        rd(A_CTRL, ctrl_byte(), "R6 read before clear 2");
        wr(A_CTRL, 8'h20);

        // R3 R4 wider modulo 0x0100, interrupt disabled
        wr(A_MODH, 8'h01);
        wr(A_MODL, 8'h00);
        wr(A_CTRL, 8'h00);
        tick(256);
        chk_cnt("R4 count high byte at 0x0100");
        rd(A_CTRL, 8'h00, "R3 no flag before match tick");
        tick(1);
        chk_cnt("R3 wide wrap to zero");
        rd(A_CTRL, 8'h80, "R3 flag after wide wrap");
        chk_irq("R8 irq low with enable off");

        idle(2);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule